// File: doc/BRIEF.md
# Byte-Serializing I/O Bus Adapter

This block joins a 16-bit processor bus to an 8-bit expansion channel. Memory requests pass through as single 16-bit transfers of a fixed length. I/O requests are carried out on the narrow channel. Each byte goes through its own cycle: an address strobe, one setup clock, and then a command phase. A request that enables both bytes becomes two byte cycles in a row, with the halves of read data gathered back into one word.

The command phase holds a fixed number of wait states. A peripheral can stretch it by pulling the channel ready line low. Each clock of low ready, seen through a two-stage synchronizer, adds one clock to the cycle. Ready that stays low too long is treated as a stuck channel. The adapter then ends the cycle, drops any byte still pending, and pulses an error output. The processor sees one ready output that stays low for the whole transaction, split or not.

Top module: `iobus_sizer`

## Requirements
- R1: A memory request (`req_io`=0) keeps `cpu_rdy` low for exactly 4 clocks. During that time `mem_sel` is high and `mem_addr`, `mem_be`, `mem_write` and `mem_wdata` carry the request unchanged. A read returns `mem_rdata` as sampled in the last of those clocks. A write returns `cpu_rdata`=0.
- R2: With ready held high, a single-byte I/O request keeps `cpu_rdy` low for exactly 8 clocks (4 base clocks plus 4 wait states). `ch_ale` is high for the first clock. The command strobe (`ch_rd` or `ch_wr`) first rises 2 clocks after the `ch_ale` clock, so one clock with neither strobe high separates them.
- R3: An I/O request with `req_be`=2'b11 runs two byte cycles, separated by one idle clock. The even address (`req_addr` with bit 0 cleared) goes first, then the odd address. `cpu_rdy` stays low for all 17 clocks.
- R4: Byte lanes: `req_be`=2'b01 runs one cycle at the even address and uses data bits 7:0. `req_be`=2'b10 runs one cycle at the odd address and uses bits 15:8. A write drives the byte of the matching lane on `ch_wdata`.
- R5: For an I/O read, each `ch_rdata` byte lands in its own lane of `cpu_rdata`, and a lane that was not transferred reads 0. The full result is valid when `cpu_rdy` returns high.
- R6: `ch_rdy` passes through a two-flop synchronizer. Each clock that the synchronized ready is low during a command phase lengthens the cycle by exactly one clock, for up to 17 consecutive clocks.
- R7: On the 18th consecutive low synchronized-ready clock, the adapter ends the transaction and skips any pending second byte. `ch_err` is then high for exactly one clock, the first clock in which `cpu_rdy` is high again. The next request runs normally.
- R8: After reset `cpu_rdy` is high and `ch_ale`, `ch_rd`, `ch_wr`, `mem_sel` and `ch_err` are low. A request is taken only while `cpu_rdy` is high.
- R9: `ch_rd` and `ch_wr` are never high together. `ch_wdata` is stable while `ch_wr` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_io | input | 1 | 1 = I/O or DMA space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| req_wdata | input | 16 | Write data |
| cpu_rdy | output | 1 | High when idle or done |
| cpu_rdata | output | 16 | Read result |
| mem_sel | output | 1 | Memory cycle active |
| mem_write | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | 2 | Memory byte enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| ch_ale | output | 1 | Channel address strobe |
| ch_rd | output | 1 | Channel read command |
| ch_wr | output | 1 | Channel write command |
| ch_addr | output | ADDR_W | Channel byte address |
| ch_wdata | output | 8 | Channel write byte |
| ch_rdata | input | 8 | Channel read byte |
| ch_rdy | input | 1 | Asynchronous channel ready |
| ch_err | output | 1 | Ready-timeout pulse |

## Verification
The bench runs memory and I/O requests over every combination of read/write and byte-enable pattern at several addresses, including one at the top of the address space. The mix of lane patterns shows whether bytes are ordered, placed and zero-filled correctly. The mix of addresses shows whether the low address bit is replaced by the lane rather than passed through. A sweep of ready-low lengths from 0 to 17 clocks, on the first byte and on the second byte of a word, checks that each stall adds exactly one clock. Lengths of 17 and 18 separate the last tolerated stall from the first one that times out.

// File: rtl/iob_sizer_pkg.sv
package iob_sizer_pkg;
   typedef enum logic [1:0] {TS_IDLE, TS_MEM, TS_IO, TS_GAP} top_state_e;
   typedef enum logic [1:0] {BS_IDLE, BS_ALE, BS_SETUP, BS_CMD} byte_state_e;
endpackage

// File: rtl/iob_rdy_sync.sv
module iob_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("iob_rdy_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], din};
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/iob_byte_seq.sv
module iob_byte_seq
   import iob_sizer_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int SETUP_CLKS = 1,
   parameter int CMD_CLKS   = 6,
   parameter int TMO_CLKS   = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [7:0]        wdata_i,
   input  logic              rdy_i,
   output logic              ale_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        wdata_o,
   output logic              fin_o,
   output logic              tmo_o
);
   localparam int SW = (SETUP_CLKS > 1) ? $clog2(SETUP_CLKS) : 1;
   localparam int CW = (CMD_CLKS > 1) ? $clog2(CMD_CLKS) : 1;
   localparam int TW = $clog2(TMO_CLKS + 1);
   localparam logic [SW-1:0] SET_LAST = SW'(SETUP_CLKS - 1);
   localparam logic [CW-1:0] CMD_LAST = CW'(CMD_CLKS - 1);
   localparam logic [TW-1:0] TMO_LIM  = TW'(TMO_CLKS);

   generate
      if (SETUP_CLKS < 1) begin : g_bad_setup
         $error("iob_byte_seq: SETUP_CLKS must be at least 1");
      end
      if (TMO_CLKS < 1) begin : g_bad_tmo
         $error("iob_byte_seq: TMO_CLKS must be at least 1");
      end
   endgenerate

   byte_state_e       st;
   logic [SW-1:0]     set_cnt;
   logic [CW-1:0]     cmd_cnt;
   logic [TW-1:0]     stall;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BS_IDLE;
         set_cnt <= '0;
         cmd_cnt <= '0;
         stall   <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (st)
            BS_IDLE: if (start_i) begin
               addr_q  <= addr_i;
               wr_q    <= wr_i;
               wdata_q <= wdata_i;
               st      <= BS_ALE;
            end
            BS_ALE: begin
               set_cnt <= '0;
               st      <= BS_SETUP;
            end
            BS_SETUP: if (set_cnt == SET_LAST) begin
               cmd_cnt <= '0;
               stall   <= '0;
               st      <= BS_CMD;
            end else begin
               set_cnt <= set_cnt + 1'b1;
            end
            BS_CMD: if (!rdy_i) begin
               if (stall == TMO_LIM) st <= BS_IDLE;
               else                  stall <= stall + 1'b1;
            end else begin
               stall <= '0;
               if (cmd_cnt == CMD_LAST) st <= BS_IDLE;
               else                     cmd_cnt <= cmd_cnt + 1'b1;
            end
            default: st <= BS_IDLE;
         endcase
      end
   end

   assign ale_o   = (st == BS_ALE);
   assign rd_o    = (st == BS_CMD) && !wr_q;
   assign wr_o    = (st == BS_CMD) && wr_q;
   assign addr_o  = addr_q;
   assign wdata_o = wdata_q;
   assign fin_o   = (st == BS_CMD) && rdy_i && (cmd_cnt == CMD_LAST);
   assign tmo_o   = (st == BS_CMD) && !rdy_i && (stall == TMO_LIM);
endmodule

// File: rtl/iobus_sizer.sv
module iobus_sizer
   import iob_sizer_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int MEM_CLKS     = 4,
   parameter int IO_BASE_CLKS = 4,
   parameter int IO_WAITS     = 4,
   parameter int SETUP_CLKS   = 1,
   parameter int GAP_CLKS     = 1,
   parameter int RDY_TMO      = 17,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_io,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_be,
   input  logic [15:0]       req_wdata,
   output logic              cpu_rdy,
   output logic [15:0]       cpu_rdata,
   output logic              mem_sel,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic              ch_ale,
   output logic              ch_rd,
   output logic              ch_wr,
   output logic [ADDR_W-1:0] ch_addr,
   output logic [7:0]        ch_wdata,
   input  logic [7:0]        ch_rdata,
   input  logic              ch_rdy,
   output logic              ch_err
);
   localparam int BYTE_CLKS = IO_BASE_CLKS + IO_WAITS;
   localparam int CMD_CLKS  = BYTE_CLKS - 1 - SETUP_CLKS;
   localparam int MW = (MEM_CLKS > 1) ? $clog2(MEM_CLKS) : 1;
   localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
   localparam logic [MW-1:0] MEM_LAST = MW'(MEM_CLKS - 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CLKS - 1);

   generate
      if (CMD_CLKS < 1) begin : g_bad_cmd
         $error("iobus_sizer: byte cycle too short for strobe and setup phases");
      end
      if (MEM_CLKS < 1) begin : g_bad_mem
         $error("iobus_sizer: MEM_CLKS must be at least 1");
      end
      if (GAP_CLKS < 1) begin : g_bad_gap
         $error("iobus_sizer: GAP_CLKS must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("iobus_sizer: ADDR_W must be at least 2");
      end
   endgenerate

   top_state_e        state;
   logic [MW-1:0]     mem_cnt;
   logic [GW-1:0]     gap_cnt;
   logic              op_wr;
   logic [ADDR_W-1:0] op_addr;
   logic [1:0]        op_be;
   logic [15:0]       op_wdata;
   logic              cur_hi;
   logic              hi_pend;
   logic [15:0]       rdata_q;
   logic              err_q;

   logic              rdy_s;
   logic              eng_start;
   logic [ADDR_W-1:0] eng_addr;
   logic              eng_wr;
   logic [7:0]        eng_wdata;
   logic              eng_fin;
   logic              eng_tmo;

   iob_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ch_rdy),
      .dout (rdy_s)
   );

   // First byte comes straight from the request; the second from the held copy.
   always_comb begin
      eng_start = 1'b0;
      eng_addr  = {req_addr[ADDR_W-1:1], (req_be == 2'b10)};
      eng_wr    = req_write;
      eng_wdata = (req_be == 2'b10) ? req_wdata[15:8] : req_wdata[7:0];
      if (state == TS_IDLE && req_valid && req_io) begin
         eng_start = 1'b1;
      end else if (state == TS_GAP && gap_cnt == GAP_LAST) begin
         eng_start = 1'b1;
         eng_addr  = {op_addr[ADDR_W-1:1], 1'b1};
         eng_wr    = op_wr;
         eng_wdata = op_wdata[15:8];
      end
   end

   iob_byte_seq #(
      .ADDR_W    (ADDR_W),
      .SETUP_CLKS(SETUP_CLKS),
      .CMD_CLKS  (CMD_CLKS),
      .TMO_CLKS  (RDY_TMO)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(eng_start),
      .addr_i (eng_addr),
      .wr_i   (eng_wr),
      .wdata_i(eng_wdata),
      .rdy_i  (rdy_s),
      .ale_o  (ch_ale),
      .rd_o   (ch_rd),
      .wr_o   (ch_wr),
      .addr_o (ch_addr),
      .wdata_o(ch_wdata),
      .fin_o  (eng_fin),
      .tmo_o  (eng_tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TS_IDLE;
         mem_cnt  <= '0;
         gap_cnt  <= '0;
         op_wr    <= 1'b0;
         op_addr  <= '0;
         op_be    <= '0;
         op_wdata <= '0;
         cur_hi   <= 1'b0;
         hi_pend  <= 1'b0;
         rdata_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= eng_tmo;
         unique case (state)
            TS_IDLE: if (req_valid) begin
               op_wr    <= req_write;
               op_addr  <= req_addr;
               op_be    <= req_be;
               op_wdata <= req_wdata;
               rdata_q  <= '0;
               if (req_io) begin
                  state   <= TS_IO;
                  cur_hi  <= (req_be == 2'b10);
                  hi_pend <= (req_be == 2'b11);
               end else begin
                  state   <= TS_MEM;
                  mem_cnt <= '0;
               end
            end
            TS_MEM: if (mem_cnt == MEM_LAST) begin
               if (!op_wr) rdata_q <= mem_rdata;
               state <= TS_IDLE;
            end else begin
               mem_cnt <= mem_cnt + 1'b1;
            end
            TS_IO: if (eng_fin) begin
               if (!op_wr) begin
                  if (cur_hi) rdata_q[15:8] <= ch_rdata;
                  else        rdata_q[7:0]  <= ch_rdata;
               end
               if (hi_pend) begin
                  hi_pend <= 1'b0;
                  gap_cnt <= '0;
                  state   <= TS_GAP;
               end else begin
                  state <= TS_IDLE;
               end
            end else if (eng_tmo) begin
               hi_pend <= 1'b0;
               state   <= TS_IDLE;
            end
            TS_GAP: if (gap_cnt == GAP_LAST) begin
               cur_hi <= 1'b1;
               state  <= TS_IO;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= TS_IDLE;
         endcase
      end
   end

   assign cpu_rdy   = (state == TS_IDLE);
   assign cpu_rdata = rdata_q;
   assign mem_sel   = (state == TS_MEM);
   assign mem_write = op_wr;
   assign mem_addr  = op_addr;
   assign mem_be    = op_be;
   assign mem_wdata = op_wdata;
   assign ch_err    = err_q;
endmodule

// File: rtl/iobus_sizer_chk.sv
module iobus_sizer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_rdy,
   input logic       mem_sel,
   input logic       ch_ale,
   input logic       ch_rd,
   input logic       ch_wr,
   input logic [7:0] ch_wdata,
   input logic       ch_err
);
   // R2
   ale_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_ale |=> !(ch_rd || ch_wr));
   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ale || ch_rd || ch_wr) |-> !cpu_rdy);
   // R1
   path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel |-> !(ch_ale || ch_rd || ch_wr));
   // R7
   err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_err |-> cpu_rdy);
   // R7
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_err |=> !ch_err);
   // R9
   cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_rd && ch_wr));
   // R9
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr && $past(ch_wr)) |-> $stable(ch_wdata));
endmodule

bind iobus_sizer iobus_sizer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_rdy (cpu_rdy),
   .mem_sel (mem_sel),
   .ch_ale  (ch_ale),
   .ch_rd   (ch_rd),
   .ch_wr   (ch_wr),
   .ch_wdata(ch_wdata),
   .ch_err  (ch_err)
);

// File: tb/iobus_sizer_test.sv
`timescale 1ns/1ps
module iobus_sizer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_io, req_write;
   logic [19:0] req_addr;
   logic [1:0]  req_be;
   logic [15:0] req_wdata;
   logic        cpu_rdy;
   logic [15:0] cpu_rdata;
   logic        mem_sel, mem_write;
   logic [19:0] mem_addr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata, mem_rdata;
   logic        ch_ale, ch_rd, ch_wr, ch_rdy, ch_err;
   logic [19:0] ch_addr;
   logic [7:0]  ch_wdata, ch_rdata;

   always #4 clk = ~clk;

   iobus_sizer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
      .mem_sel(mem_sel), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ch_ale(ch_ale), .ch_rd(ch_rd), .ch_wr(ch_wr), .ch_addr(ch_addr),
      .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .ch_rdy(ch_rdy), .ch_err(ch_err)
   );

   // Peripheral and memory models
   assign ch_rdata  = ch_addr[7:0] ^ 8'h5A;
   assign mem_rdata = {~mem_addr[7:0], mem_addr[7:0]};

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   int          r_len, r_ale_n, r_wr_n, r_setup;
   logic [15:0] r_data;
   bit          r_err, r_err_after, r_mem_seen;
   logic [19:0] r_ale_addr [4];
   logic [19:0] r_wr_addr  [4];
   logic [7:0]  r_wr_data  [4];
   logic [19:0] r_mem_addr;
   logic [1:0]  r_mem_be;
   logic        r_mem_we;
   logic [15:0] r_mem_wd;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input bit io, input bit wr, input logic [19:0] a,
                        input logic [1:0] be, input logic [15:0] wd,
                        input int stall_n, input int stall_byte);
      int  remain = 0;
      int  cmd_idx = 0;
      int  ale_at = 0;
      bit  prev_cmd = 1'b0;
      bit  cmd;
      r_len = 0; r_ale_n = 0; r_wr_n = 0; r_setup = 0; r_mem_seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_io = io; req_write = wr;
      req_addr = a; req_be = be; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!cpu_rdy) begin
         r_len++;
         if (r_len > 400) begin
            chk(1'b0, "R8", "transaction never ended", r_len, 0);
            break;
         end
         if (ch_ale) begin
            if (r_ale_n < 4) r_ale_addr[r_ale_n] = ch_addr;
            r_ale_n++;
            ale_at = r_len;
         end
         if (remain > 0) begin
            remain--;
            if (remain == 0) ch_rdy = 1'b1;
         end
         cmd = ch_rd || ch_wr;
         if (cmd && !prev_cmd) begin
            cmd_idx++;
            r_setup = r_len - ale_at;
            if (ch_wr && r_wr_n < 4) begin
               r_wr_addr[r_wr_n] = ch_addr;
               r_wr_data[r_wr_n] = ch_wdata;
               r_wr_n++;
            end
            if (cmd_idx == stall_byte && stall_n > 0) begin
               ch_rdy = 1'b0;
               remain = stall_n;
            end
         end
         if (mem_sel && !r_mem_seen) begin
            r_mem_seen = 1'b1;
            r_mem_addr = mem_addr; r_mem_be = mem_be;
            r_mem_we = mem_write; r_mem_wd = mem_wdata;
         end
         prev_cmd = cmd;
         @(negedge clk);
      end
      r_err  = ch_err;
      r_data = cpu_rdata;
      ch_rdy = 1'b1;
      @(negedge clk);
      r_err_after = ch_err;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [15:0] io_exp(input logic [19:0] a, input logic [1:0] be);
      logic [19:0] base = {a[19:1], 1'b0};
      logic [7:0]  lo = base[7:0] ^ 8'h5A;
      logic [7:0]  hi = (base[7:0] | 8'h01) ^ 8'h5A;
      case (be)
         2'b01:   return {8'h00, lo};
         2'b10:   return {hi, 8'h00};
         default: return {hi, lo};
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL R8 watchdog expired: actual=%0h expected=%0h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [19:0] addrs [4];
      logic [19:0] base;
      logic [15:0] wd;
      addrs[0] = 20'h003F8; addrs[1] = 20'h00061; addrs[2] = 20'hFFFFE; addrs[3] = 20'h12345;
      rst_n = 1'b0; req_valid = 1'b0; req_io = 1'b0; req_write = 1'b0;
      req_addr = '0; req_be = 2'b00; req_wdata = '0; ch_rdy = 1'b1;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(cpu_rdy == 1'b1, "R8", "cpu_rdy in reset", cpu_rdy, 1);
      chk({ch_ale, ch_rd, ch_wr, mem_sel, ch_err} == 5'b0, "R8", "strobes in reset",
          {ch_ale, ch_rd, ch_wr, mem_sel, ch_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cpu_rdy == 1'b1, "R8", "cpu_rdy after reset", cpu_rdy, 1);

      // R1 memory sweep
      for (int ai = 0; ai < 4; ai++) begin
         for (int b = 1; b < 4; b++) begin
            for (int w = 0; w < 2; w++) begin
               wd = 16'hC3A5 ^ 16'(ai * 16'h1111) ^ 16'(b);
               do_op(1'b0, w[0], addrs[ai], b[1:0], wd, 0, 0);
               chk(r_len == 4, "R1", "memory cycle length", r_len, 4);
               chk(r_mem_seen && r_mem_addr == addrs[ai] && r_mem_be == b[1:0] &&
                   r_mem_we == w[0], "R1", "memory address/be/we", r_mem_addr, addrs[ai]);
               chk(r_ale_n == 0, "R1", "no channel strobe on memory", r_ale_n, 0);
               if (w == 1) begin
                  chk(r_mem_wd == wd, "R1", "memory write data", r_mem_wd, wd);
                  chk(r_data == 16'h0, "R1", "write returns zero", r_data, 0);
               end else begin
                  chk(r_data == {~addrs[ai][7:0], addrs[ai][7:0]}, "R1", "memory read word",
                      r_data, {~addrs[ai][7:0], addrs[ai][7:0]});
               end
            end
         end
      end

      // R2 R3 R4 R5 I/O sweep
      for (int ai = 0; ai < 4; ai++) begin
         for (int b = 1; b < 4; b++) begin
            for (int w = 0; w < 2; w++) begin
               wd = 16'h9E21 ^ 16'(ai * 16'h0F0F) ^ 16'(b << 4);
               base = {addrs[ai][19:1], 1'b0};
               do_op(1'b1, w[0], addrs[ai], b[1:0], wd, 0, 0);
               if (b == 3) begin
                  chk(r_len == 17, "R3", "word I/O length", r_len, 17);
                  chk(r_ale_n == 2, "R3", "two byte cycles", r_ale_n, 2);
                  chk(r_ale_addr[0] == base && r_ale_addr[1] == (base | 20'h1), "R3",
                      "even then odd address", r_ale_addr[1], base | 20'h1);
               end else begin
                  chk(r_len == 8, "R2", "byte I/O length", r_len, 8);
                  chk(r_ale_n == 1, "R4", "one byte cycle", r_ale_n, 1);
                  chk(r_ale_addr[0] == (b == 2 ? (base | 20'h1) : base), "R4",
                      "lane address", r_ale_addr[0], b == 2 ? (base | 20'h1) : base);
               end
               chk(r_setup == 2, "R2", "strobe-to-command spacing", r_setup, 2);
               chk(r_err == 1'b0, "R7", "no error without stall", r_err, 0);
               if (w == 1) begin
                  chk(r_data == 16'h0, "R5", "write returns zero", r_data, 0);
                  if (b == 3) begin
                     chk(r_wr_n == 2 && r_wr_data[0] == wd[7:0] && r_wr_data[1] == wd[15:8],
                         "R4", "word write byte order", {r_wr_data[0], r_wr_data[1]},
                         {wd[7:0], wd[15:8]});
                  end else begin
                     chk(r_wr_n == 1 && r_wr_data[0] == (b == 2 ? wd[15:8] : wd[7:0]),
                         "R4", "byte write lane", r_wr_data[0], b == 2 ? wd[15:8] : wd[7:0]);
                  end
               end else begin
                  chk(r_data == io_exp(addrs[ai], b[1:0]), "R5", "read reassembly",
                      r_data, io_exp(addrs[ai], b[1:0]));
               end
            end
         end
      end

      // R6 stall sweep on a single byte read, up to the tolerated limit
      for (int n = 0; n <= 17; n++) begin
         do_op(1'b1, 1'b0, 20'h00278, 2'b01, 16'h0, n, 1);
         chk(r_len == 8 + n, "R6", "stall extends byte cycle", r_len, 8 + n);
         chk(r_err == 1'b0, "R7", "no timeout at or below limit", r_err, 0);
         chk(r_data == io_exp(20'h00278, 2'b01), "R6", "stalled read data",
             r_data, io_exp(20'h00278, 2'b01));
      end

      // R6 stall on the second byte of a word
      for (int n = 1; n <= 9; n += 4) begin
         do_op(1'b1, 1'b0, 20'h00330, 2'b11, 16'h0, n, 2);
         chk(r_len == 17 + n, "R6", "stall in second byte", r_len, 17 + n);
         chk(r_data == io_exp(20'h00330, 2'b11), "R6", "stalled word data",
             r_data, io_exp(20'h00330, 2'b11));
      end

      // R7 timeout on the first byte of a word
      do_op(1'b1, 1'b0, 20'h00340, 2'b11, 16'h0, 18, 1);
      chk(r_err == 1'b1, "R7", "error pulse on release", r_err, 1);
      chk(r_err_after == 1'b0, "R7", "error pulse one clock", r_err_after, 0);
      chk(r_len == 22, "R7", "aborted cycle length", r_len, 22);
      chk(r_ale_n == 1, "R7", "second byte dropped", r_ale_n, 1);

      // R7 timeout during a write, then recovery
      do_op(1'b1, 1'b1, 20'h00342, 2'b01, 16'h00AB, 25, 1);
      chk(r_err == 1'b1, "R7", "write timeout error", r_err, 1);
      do_op(1'b1, 1'b0, 20'h00344, 2'b10, 16'h0, 0, 0);
      chk(r_len == 8 && r_err == 1'b0, "R7", "recovery cycle length", r_len, 8);
      chk(r_data == io_exp(20'h00344, 2'b10), "R7", "recovery read data",
          r_data, io_exp(20'h00344, 2'b10));

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule